// File: doc/BRIEF.md
# Programming Page Buffer with Loaded-Location Mask

This block is the target-side staging buffer for paged non-volatile writes in a serial programming path. A front end that has already shifted in and decoded the commands drives it with byte loads. Each load carries an in-page offset, a data byte and a memory-kind select. For the word-organised program memory, each 16-bit word is built from a low byte followed by a high byte at the same offset. For the byte-organised data memory (EEPROM), each load fills one byte.

A commit names a memory kind and a page number. It copies into the backing array only the locations of that kind's buffer that were completed since the previous commit. All other locations of the page keep their old contents, so no separate erase is needed. The commit then clears that buffer's mask and raises a busy flag for a fixed write time. Loads and commits that arrive while the flag is high are dropped.

Reads are combinational. They return the stored content at a full address, which is the page number above the in-page offset. Both arrays come out of reset in the erased state, with every byte equal to 0xFF.

Top module: `prog_page_buf`

## Requirements
- R1: After reset, every byte of both arrays reads 0xFF, `busy_o` is 0 and `order_err_o` is 0.
- R2: An EEPROM load (`load_mem_i`=1) at offset `load_ofs_i` followed by an EEPROM commit to page P makes a read with `rd_mem_i`=1 at address {P, offset} return the loaded byte.
- R3: An EEPROM commit changes only the offsets loaded since the previous EEPROM commit. All other bytes of the page keep their previous values, and a reload of a location overwrites it.
- R4: A program-memory word is complete when a low-byte load (`load_mem_i`=0, `load_hi_i`=0) is followed by a high-byte load (`load_hi_i`=1) at the same offset. A commit writes both bytes. A read with `rd_mem_i`=0 returns the low byte for `rd_hi_i`=0 and the high byte for `rd_hi_i`=1.
- R5: A high-byte load at an offset with no pending low byte pulses `order_err_o` high for exactly the cycle after the load. That word is not marked for commit.
- R6: A low byte with no following high byte is not written by a commit.
- R7: A commit clears the loaded mask and pending low bytes of its own memory kind. A later commit with no new loads writes nothing, and a commit of one kind leaves the other array unchanged.
- R8: An accepted commit holds `busy_o` high for exactly WRITE_CYCLES clock cycles, starting on the edge that takes the commit.
- R9: While `busy_o` is high, loads and commits are ignored.
- R10: When a load and a commit are presented in the same cycle, the commit is taken and the load is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| load_i | input | 1 | Byte load strobe |
| load_mem_i | input | 1 | Load target: 0 program memory, 1 EEPROM |
| load_hi_i | input | 1 | Program memory: 1 high byte, 0 low byte |
| load_ofs_i | input | OFS_W | In-page offset of the load |
| load_data_i | input | 8 | Byte to load |
| commit_i | input | 1 | Page commit strobe |
| commit_mem_i | input | 1 | Commit target: 0 program memory, 1 EEPROM |
| commit_page_i | input | PAGE_W | Page number written by the commit |
| rd_mem_i | input | 1 | Read source: 0 program memory, 1 EEPROM |
| rd_hi_i | input | 1 | Program memory read: 1 high byte, 0 low byte |
| rd_addr_i | input | PAGE_W+OFS_W | Full read address {page, offset} |
| rd_data_o | output | 8 | Stored byte at the read address |
| busy_o | output | 1 | Write in progress |
| order_err_o | output | 1 | One-cycle pulse for a high byte without a pending low byte |

## Verification
Assertions check on every cycle that an ordering violation produces the error pulse and leaves the word mask unchanged. They also check that an accepted commit raises busy and that the busy counter never exceeds its limit, and that no mask moves while busy or after a commit clears it. Only the bench scenarios can show that the array contents are right. That covers which bytes a commit writes and which it spares, the low/high word selection on reads, the exact busy length, and that loads dropped while busy or beside a commit never reach memory.

// File: rtl/ppb_pkg.sv
package ppb_pkg;
  typedef enum logic {
    MEM_PROG = 1'b0,
    MEM_EE   = 1'b1
  } mem_kind_e;
endpackage

// File: rtl/ppb_busy_timer.sv
module ppb_busy_timer #(
  parameter int unsigned WRITE_CYCLES = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o
);
  localparam int unsigned CNT_W = $clog2(WRITE_CYCLES + 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (start_i)          cnt_q <= CNT_W'(WRITE_CYCLES);
    else if (cnt_q != '0)      cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);

  assert_busy_start_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> busy_o);
  assert_busy_bound_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(WRITE_CYCLES));
endmodule

// File: rtl/ppb_word_buf.sv
module ppb_word_buf #(
  parameter int unsigned OFS_W = 6,
  localparam int unsigned LOCS = 1 << OFS_W
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        ld_i,
  input  logic                        hi_i,
  input  logic [OFS_W-1:0]            ofs_i,
  input  logic [7:0]                  data_i,
  input  logic                        clr_i,
  output logic [LOCS-1:0][15:0]       word_o,
  output logic [LOCS-1:0]             mask_o,
  output logic                        err_o
);
  logic [LOCS-1:0] lo_seen_q;
  logic            bad_hi;

  assign bad_hi = ld_i && hi_i && !lo_seen_q[ofs_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_o    <= '1;
      mask_o    <= '0;
      lo_seen_q <= '0;
      err_o     <= 1'b0;
    end else begin
      err_o <= 1'b0;
      if (clr_i) begin
        mask_o    <= '0;
        lo_seen_q <= '0;
      end else if (ld_i) begin
        if (!hi_i) begin
          word_o[ofs_i][7:0] <= data_i;
          lo_seen_q[ofs_i]   <= 1'b1;
          mask_o[ofs_i]      <= 1'b0;   // word pending until its high byte
        end else if (lo_seen_q[ofs_i]) begin
          word_o[ofs_i][15:8] <= data_i;
          mask_o[ofs_i]       <= 1'b1;
          lo_seen_q[ofs_i]    <= 1'b0;
        end else begin
          err_o <= 1'b1;
        end
      end
    end
  end

  assert_order_err_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bad_hi && !clr_i) |=> err_o);
  assert_order_mask_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bad_hi && !clr_i) |=> $stable(mask_o));
  assert_clr_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (mask_o == '0));
endmodule

// File: rtl/ppb_byte_buf.sv
module ppb_byte_buf #(
  parameter int unsigned OFS_W = 6,
  localparam int unsigned LOCS = 1 << OFS_W
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  ld_i,
  input  logic [OFS_W-1:0]      ofs_i,
  input  logic [7:0]            data_i,
  input  logic                  clr_i,
  output logic [LOCS-1:0][7:0]  byte_o,
  output logic [LOCS-1:0]       mask_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      byte_o <= '1;
      mask_o <= '0;
    end else if (clr_i) begin
      mask_o <= '0;
    end else if (ld_i) begin
      byte_o[ofs_i] <= data_i;
      mask_o[ofs_i] <= 1'b1;
    end
  end

  assert_mask_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ld_i && !clr_i) |=> $stable(mask_o));
  assert_clr_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (mask_o == '0));
endmodule

// File: rtl/ppb_array.sv
module ppb_array #(
  parameter int unsigned DW     = 8,
  parameter int unsigned OFS_W  = 6,
  parameter int unsigned PAGE_W = 3,
  localparam int unsigned LOCS  = 1 << OFS_W,
  localparam int unsigned AW    = PAGE_W + OFS_W,
  localparam int unsigned DEPTH = 1 << AW
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   wr_en_i,
  input  logic [PAGE_W-1:0]      wr_page_i,
  input  logic [LOCS-1:0]        wr_mask_i,
  input  logic [LOCS-1:0][DW-1:0] wr_data_i,
  input  logic [AW-1:0]          rd_addr_i,
  output logic [DW-1:0]          rd_data_o
);
  logic [DW-1:0] mem_q [DEPTH];

  // erased state is all ones
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int a = 0; a < DEPTH; a++) mem_q[a] <= '1;
    end else if (wr_en_i) begin
      for (int i = 0; i < LOCS; i++) begin
        if (wr_mask_i[i]) mem_q[{wr_page_i, OFS_W'(i)}] <= wr_data_i[i];
      end
    end
  end

  assign rd_data_o = mem_q[rd_addr_i];
endmodule

// File: rtl/prog_page_buf.sv
module prog_page_buf
  import ppb_pkg::*;
#(
  parameter int unsigned OFS_W        = 6,
  parameter int unsigned PAGE_W       = 3,
  parameter int unsigned WRITE_CYCLES = 16,
  localparam int unsigned LOCS        = 1 << OFS_W,
  localparam int unsigned AW          = PAGE_W + OFS_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              load_mem_i,
  input  logic              load_hi_i,
  input  logic [OFS_W-1:0]  load_ofs_i,
  input  logic [7:0]        load_data_i,
  input  logic              commit_i,
  input  logic              commit_mem_i,
  input  logic [PAGE_W-1:0] commit_page_i,
  input  logic              rd_mem_i,
  input  logic              rd_hi_i,
  input  logic [AW-1:0]     rd_addr_i,
  output logic [7:0]        rd_data_o,
  output logic              busy_o,
  output logic              order_err_o
);
  logic ld_acc, cm_acc;
  logic pm_ld, ee_ld, pm_cm, ee_cm;

  logic [LOCS-1:0][15:0] pm_word;
  logic [LOCS-1:0]       pm_mask;
  logic [LOCS-1:0][7:0]  ee_byte;
  logic [LOCS-1:0]       ee_mask;
  logic [15:0]           pm_rd;
  logic [7:0]            ee_rd;

  // commit wins over a simultaneous load; busy blocks both
  assign cm_acc = commit_i && !busy_o;
  assign ld_acc = load_i && !busy_o && !commit_i;

  assign pm_ld = ld_acc && (mem_kind_e'(load_mem_i) == MEM_PROG);
  assign ee_ld = ld_acc && (mem_kind_e'(load_mem_i) == MEM_EE);
  assign pm_cm = cm_acc && (mem_kind_e'(commit_mem_i) == MEM_PROG);
  assign ee_cm = cm_acc && (mem_kind_e'(commit_mem_i) == MEM_EE);

  ppb_word_buf #(.OFS_W(OFS_W)) u_pm_buf (
    .clk_i (clk_i), .rst_ni(rst_ni),
    .ld_i  (pm_ld), .hi_i  (load_hi_i), .ofs_i(load_ofs_i), .data_i(load_data_i),
    .clr_i (pm_cm),
    .word_o(pm_word), .mask_o(pm_mask), .err_o(order_err_o)
  );

  ppb_byte_buf #(.OFS_W(OFS_W)) u_ee_buf (
    .clk_i (clk_i), .rst_ni(rst_ni),
    .ld_i  (ee_ld), .ofs_i (load_ofs_i), .data_i(load_data_i),
    .clr_i (ee_cm),
    .byte_o(ee_byte), .mask_o(ee_mask)
  );

  ppb_array #(.DW(16), .OFS_W(OFS_W), .PAGE_W(PAGE_W)) u_pm_mem (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .wr_en_i(pm_cm), .wr_page_i(commit_page_i), .wr_mask_i(pm_mask), .wr_data_i(pm_word),
    .rd_addr_i(rd_addr_i), .rd_data_o(pm_rd)
  );

  ppb_array #(.DW(8), .OFS_W(OFS_W), .PAGE_W(PAGE_W)) u_ee_mem (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .wr_en_i(ee_cm), .wr_page_i(commit_page_i), .wr_mask_i(ee_mask), .wr_data_i(ee_byte),
    .rd_addr_i(rd_addr_i), .rd_data_o(ee_rd)
  );

  ppb_busy_timer #(.WRITE_CYCLES(WRITE_CYCLES)) u_busy (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(cm_acc), .busy_o(busy_o)
  );

  always_comb begin
    if (mem_kind_e'(rd_mem_i) == MEM_EE) rd_data_o = ee_rd;
    else if (rd_hi_i)                    rd_data_o = pm_rd[15:8];
    else                                 rd_data_o = pm_rd[7:0];
  end

  assert_busy_ignore_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !commit_i) |=> ($stable(ee_mask) && $stable(pm_mask)));
  assert_commit_busy_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit_i && !busy_o) |=> busy_o);
  assert_err_pulse_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> !order_err_o);
endmodule

// File: tb/prog_page_buf_tb.sv
module prog_page_buf_tb;
  localparam int CLK_PERIOD = 10;
  localparam int OFS_W = 6;
  localparam int PAGE_W = 3;
  localparam int WC = 16;
  localparam int AW = PAGE_W + OFS_W;

  localparam logic [1:0] OP_LD = 2'd0, OP_CM = 2'd1, OP_RD = 2'd2;

  typedef struct packed {
    logic [1:0]    op;
    logic          mem;
    logic          hi;
    logic [AW-1:0] addr;   // commit: page in high bits; load: offset in low bits
    logic [7:0]    data;   // load data or expected read value
    logic [3:0]    req;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VECS [NV] = '{
    '{OP_LD, 1'b1, 1'b0, 9'h005, 8'h3C, 4'd2},
    '{OP_LD, 1'b1, 1'b0, 9'h006, 8'h7E, 4'd2},
    '{OP_CM, 1'b1, 1'b0, 9'h080, 8'h00, 4'd2},
    '{OP_RD, 1'b1, 1'b0, 9'h085, 8'h3C, 4'd2},  // R2
    '{OP_RD, 1'b1, 1'b0, 9'h086, 8'h7E, 4'd2},
    '{OP_RD, 1'b1, 1'b0, 9'h087, 8'hFF, 4'd3},  // R3 unloaded byte
    '{OP_LD, 1'b1, 1'b0, 9'h006, 8'h11, 4'd3},
    '{OP_CM, 1'b1, 1'b0, 9'h080, 8'h00, 4'd3},
    '{OP_RD, 1'b1, 1'b0, 9'h085, 8'h3C, 4'd3},  // R3 kept
    '{OP_RD, 1'b1, 1'b0, 9'h086, 8'h11, 4'd3},
    '{OP_LD, 1'b0, 1'b0, 9'h003, 8'hA1, 4'd4},
    '{OP_LD, 1'b0, 1'b1, 9'h003, 8'hB2, 4'd4},
    '{OP_LD, 1'b0, 1'b0, 9'h009, 8'h44, 4'd6},
    '{OP_CM, 1'b0, 1'b0, 9'h040, 8'h00, 4'd4},
    '{OP_RD, 1'b0, 1'b0, 9'h043, 8'hA1, 4'd4},  // R4 low
    '{OP_RD, 1'b0, 1'b1, 9'h043, 8'hB2, 4'd4},  // R4 high
    '{OP_RD, 1'b0, 1'b0, 9'h049, 8'hFF, 4'd6},  // R6
    '{OP_CM, 1'b0, 1'b0, 9'h100, 8'h00, 4'd7},
    '{OP_RD, 1'b0, 1'b0, 9'h103, 8'hFF, 4'd7},  // R7 mask cleared
    '{OP_RD, 1'b1, 1'b0, 9'h043, 8'hFF, 4'd7}   // R7 other kind untouched
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic load = 1'b0, load_mem = 1'b0, load_hi = 1'b0;
  logic [OFS_W-1:0] load_ofs = '0;
  logic [7:0] load_data = '0;
  logic commit = 1'b0, commit_mem = 1'b0;
  logic [PAGE_W-1:0] commit_page = '0;
  logic rd_mem = 1'b0, rd_hi = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic busy, order_err;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  prog_page_buf #(.OFS_W(OFS_W), .PAGE_W(PAGE_W), .WRITE_CYCLES(WC)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .load_i(load), .load_mem_i(load_mem), .load_hi_i(load_hi),
    .load_ofs_i(load_ofs), .load_data_i(load_data),
    .commit_i(commit), .commit_mem_i(commit_mem), .commit_page_i(commit_page),
    .rd_mem_i(rd_mem), .rd_hi_i(rd_hi), .rd_addr_i(rd_addr),
    .rd_data_o(rd_data), .busy_o(busy), .order_err_o(order_err)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_load(input logic m, input logic h, input logic [OFS_W-1:0] o,
                         input logic [7:0] d);
    @(negedge clk);
    load = 1'b1; load_mem = m; load_hi = h; load_ofs = o; load_data = d;
    @(negedge clk);
    load = 1'b0;
  endtask

  task automatic do_commit(input logic m, input logic [PAGE_W-1:0] p);
    @(negedge clk);
    commit = 1'b1; commit_mem = m; commit_page = p;
    @(negedge clk);
    commit = 1'b0;
    while (busy) @(negedge clk);
  endtask

  task automatic do_read(input string req, input logic m, input logic h,
                         input logic [AW-1:0] a, input logic [7:0] exp);
    @(negedge clk);
    rd_mem = m; rd_hi = h; rd_addr = a;
    #1;
    check(req, int'(rd_data), int'(exp));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    do_read("R1", 1'b1, 1'b0, 9'h000, 8'hFF);
    do_read("R1", 1'b0, 1'b1, 9'h1FF, 8'hFF);
    do_read("R1", 1'b0, 1'b0, 9'h0AA, 8'hFF);
    check("R1", int'(busy), 0);
    check("R1", int'(order_err), 0);

    for (int i = 0; i < NV; i++) begin
      case (VECS[i].op)
        OP_LD: do_load(VECS[i].mem, VECS[i].hi, VECS[i].addr[OFS_W-1:0], VECS[i].data);
        OP_CM: do_commit(VECS[i].mem, VECS[i].addr[AW-1:OFS_W]);
        default: do_read($sformatf("R%0d", VECS[i].req), VECS[i].mem, VECS[i].hi,
                         VECS[i].addr, VECS[i].data);
      endcase
    end

    // R5: high byte without low byte
    @(negedge clk);
    load = 1'b1; load_mem = 1'b0; load_hi = 1'b1; load_ofs = 6'd10; load_data = 8'h55;
    @(negedge clk);
    load = 1'b0;
    check("R5", int'(order_err), 1);
    @(negedge clk);
    check("R5", int'(order_err), 0);
    do_commit(1'b0, 3'd5);
    do_read("R5", 1'b0, 1'b1, 9'h14A, 8'hFF);

    // R8: busy length
    begin
      int cyc = 0;
      @(negedge clk);
      commit = 1'b1; commit_mem = 1'b1; commit_page = 3'd0;
      @(negedge clk);
      commit = 1'b0;
      while (busy && cyc < 4*WC) begin cyc++; @(negedge clk); end
      check("R8", cyc, WC);
    end

    // R9: load and commit while busy are dropped
    @(negedge clk);
    commit = 1'b1; commit_mem = 1'b1; commit_page = 3'd6;
    @(negedge clk);
    commit = 1'b0;
    load = 1'b1; load_mem = 1'b1; load_hi = 1'b0; load_ofs = 6'd1; load_data = 8'h99;
    @(negedge clk);
    load = 1'b0;
    commit = 1'b1; commit_page = 3'd6;
    @(negedge clk);
    commit = 1'b0;
    while (busy) @(negedge clk);
    do_commit(1'b1, 3'd6);
    do_read("R9", 1'b1, 1'b0, 9'h181, 8'hFF);

    // R10: simultaneous load and commit
    @(negedge clk);
    commit = 1'b1; commit_mem = 1'b1; commit_page = 3'd7;
    load = 1'b1; load_mem = 1'b1; load_hi = 1'b0; load_ofs = 6'd2; load_data = 8'h5A;
    @(negedge clk);
    commit = 1'b0; load = 1'b0;
    check("R10", int'(busy), 1);
    while (busy) @(negedge clk);
    do_commit(1'b1, 3'd7);
    do_read("R10", 1'b1, 1'b0, 9'h1C2, 8'hFF);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule